// File: doc/BRIEF.md
# Per-Source Layer Resequencing Collector

At a destination node, each source spreads its packet flow over K parallel layers, taking the layers in a fixed rotation. The receiving side keeps one queue per (source, layer) pair. This collector puts each source's flow back in order. It keeps one pointer per source that names the layer whose queue must supply that source's next packet.

If the named queue is empty, the source simply waits, even when its other layers already hold packets. When the named queue has a packet, the source is a candidate for output. A rotating arbiter picks one candidate per cycle and presents its head packet on a valid/ready stream, together with the source index and the layer. When the transfer is accepted, the collector pops that queue and moves the source's pointer on to the next live layer. A failed-layer mask removes layers from every rotation. The mask must match the sender's mask, so it is taken in only on a frame boundary. A per-source resync input sets a pointer back to the start of the rotation. This is the recovery hook after a packet has been lost.

Top module: `layer_reseq_collector`

## Requirements
- R1: After reset every source pointer names layer 0, the failed-layer mask is clear, and the arbiter favours source 0 first.
- R2: A source is offered only when the queue at its effective layer is non-empty. It never pops a different layer out of turn, and with no offerable source `out_valid` is low.
- R3: `q_pop` has at most one bit set. The bit is set only in a cycle where `out_valid` and `out_ready` are both high, and it is the bit at index src*NLAYER+layer of the offered packet. Head data for that queue lies at bits [(src*NLAYER+layer)*DW +: DW] of `q_data`.
- R4: A pointer changes only on an accepted transfer of its source or on a resync of that source. While `out_ready` is low the offered layer does not move.
- R5: Among offerable sources, the grant goes to the first source at or after a rotating start index. After each accepted transfer the start index becomes the granted source plus one, wrapping at NSRC.
- R6: A layer whose bit is set in the active mask is never offered or popped. A pointer resting on a failed layer behaves as the next live layer in ascending cyclic order.
- R7: `fail_mask` is copied into the active mask only in a cycle with `frame_start` high, and it takes effect from the next cycle.
- R8: `resync_valid` sets the pointer of source `resync_src` to layer 0, which means the first live layer. This has priority over an advance of the same source in the same cycle.
- R9: When a sender rotates over the same live layers from the same start, each source's packets leave in their sent order. Losing one packet makes later packets leave out of order, and a resync on both sides restores order.
- R10: When every layer is failed, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary strobe that loads the mask |
| fail_mask | input | NLAYER | Failed-layer mask, one bit per layer |
| resync_valid | input | 1 | Resync strobe |
| resync_src | input | SW | Source whose pointer is reset |
| q_empty | input | NSRC*NLAYER | Empty flag per (source, layer) queue |
| q_data | input | NSRC*NLAYER*DW | Head data per queue |
| q_pop | output | NSRC*NLAYER | Pop strobe per queue |
| out_valid | output | 1 | Packet offered |
| out_ready | input | 1 | Downstream accepts |
| out_src | output | SW | Source of offered packet |
| out_layer | output | LW | Layer of offered packet |
| out_data | output | DW | Offered packet |

## Verification
The bench builds the collector with three sources and four layers. Three sources put the arbiter's wrap at a count that is not a power of two. Four layers allow masks that fail a middle layer, the edge layers, or every layer, so pointer skipping, wrap-around and the all-failed stall are all reached. Queue contents are bench models fed by a rotating sender model. This exposes out-of-turn pops, loss-induced misordering and resync recovery at the ports.

// File: rtl/layer_reseq_collector.sv
module layer_reseq_collector #(
  parameter int NSRC   = 3,
  parameter int NLAYER = 4,
  parameter int DW     = 16,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int LW = (NLAYER > 1) ? $clog2(NLAYER) : 1,
  localparam int NQ = NSRC * NLAYER
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic [NLAYER-1:0]    fail_mask,
  input  logic                 resync_valid,
  input  logic [SW-1:0]        resync_src,
  input  logic [NQ-1:0]        q_empty,
  input  logic [NQ*DW-1:0]     q_data,
  output logic [NQ-1:0]        q_pop,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [SW-1:0]        out_src,
  output logic [LW-1:0]        out_layer,
  output logic [DW-1:0]        out_data
);

  logic [NLAYER-1:0] fail_q;
  logic [LW-1:0]     ptr_q [NSRC];
  logic [LW-1:0]     eff   [NSRC];
  logic [LW-1:0]     nxt   [NSRC];
  logic [NSRC-1:0]   ready;
  logic [SW-1:0]     rr_q, grant, grant_inc;
  logic [NSRC*LW-1:0] ptr_flat;
  logic              live, acc;
  int                sel;

  assign live = ~&fail_q;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      logic fnd, fnx;
      eff[s] = ptr_q[s];
      nxt[s] = ptr_q[s];
      fnd = 1'b0;
      fnx = 1'b0;
      for (int k = 0; k < NLAYER; k++) begin
        int l;
        l = (int'(ptr_q[s]) + k) % NLAYER;
        if (!fnd && !fail_q[l]) begin
          eff[s] = LW'(l);
          fnd = 1'b1;
        end
      end
      for (int k = 1; k <= NLAYER; k++) begin
        int l;
        l = (int'(eff[s]) + k) % NLAYER;
        if (!fnx && !fail_q[l]) begin
          nxt[s] = LW'(l);
          fnx = 1'b1;
        end
      end
      ready[s] = live && !q_empty[s*NLAYER + int'(eff[s])];
      ptr_flat[s*LW +: LW] = ptr_q[s];
    end
  end

  always_comb begin
    logic gf;
    gf = 1'b0;
    grant = '0;
    for (int k = 0; k < NSRC; k++) begin
      int s;
      s = (int'(rr_q) + k) % NSRC;
      if (!gf && ready[s]) begin
        grant = SW'(s);
        gf = 1'b1;
      end
    end
    grant_inc = (int'(grant) == NSRC - 1) ? '0 : grant + 1'b1;
  end

  assign out_valid = |ready;
  assign out_src   = grant;
  assign out_layer = eff[grant];
  assign sel       = int'(grant) * NLAYER + int'(eff[grant]);
  assign out_data  = q_data[sel*DW +: DW];
  assign acc       = out_valid && out_ready;
  assign q_pop     = acc ? (NQ'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_q <= '0;
      rr_q   <= '0;
      for (int s = 0; s < NSRC; s++) ptr_q[s] <= '0;
    end else begin
      if (frame_start) fail_q <= fail_mask;
      if (acc) rr_q <= grant_inc;
      for (int s = 0; s < NSRC; s++) begin
        if (resync_valid && int'(resync_src) == s) ptr_q[s] <= '0;
        else if (acc && int'(grant) == s) ptr_q[s] <= nxt[s];
      end
    end
  end

  assert_pop_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop));
  assert_pop_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_pop) |-> (out_ready && out_valid));
  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop & q_empty) == '0);
  assert_no_failed_layer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !fail_q[out_layer]);
  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fail_q));
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !resync_valid) |=> $stable(ptr_flat));
  assert_allfail_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&fail_q) |-> !out_valid);

endmodule

// File: tb/layer_reseq_collector_tb.sv
module layer_reseq_collector_tb;
  localparam int NS = 3, NL = 4, DW = 16, SW = 2, LW = 2, NQ = NS*NL;

  logic clk = 0, rst_n = 0, frame_start = 0, resync_valid = 0, out_ready = 0;
  logic [NL-1:0] fail_mask = '0;
  logic [SW-1:0] resync_src = '0;
  logic [NQ-1:0] q_empty, q_pop;
  logic [NQ*DW-1:0] q_data;
  logic out_valid;
  logic [SW-1:0] out_src;
  logic [LW-1:0] out_layer;
  logic [DW-1:0] out_data;

  layer_reseq_collector #(.NSRC(NS), .NLAYER(NL), .DW(DW)) u_dut (.*);

  always #10 clk = ~clk;

  int fq [NS][NL][$];
  int snd_ptr [NS];
  int snd_seq [NS];
  int exp_seq [NS];
  logic [NL-1:0] snd_fail;
  int errors = 0, checks = 0, mism = 0, rcv = 0, proto = 0;
  logic track = 0, last_acc;
  int last_src, last_layer, last_data;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive();
    for (int s = 0; s < NS; s++)
      for (int l = 0; l < NL; l++) begin
        q_empty[s*NL+l] = (fq[s][l].size() == 0);
        q_data[(s*NL+l)*DW +: DW] = (fq[s][l].size() != 0) ? DW'(fq[s][l][0]) : '0;
      end
  endtask

  task automatic tick();
    logic [NQ-1:0] p;
    drive();
    #1;
    p = q_pop;
    last_acc = out_valid && out_ready;
    last_src = int'(out_src);
    last_layer = int'(out_layer);
    last_data = int'(out_data);
    if ($countones(p) != (last_acc ? 1 : 0)) proto++;
    if (last_acc && !p[last_src*NL+last_layer]) proto++;
    if (track && last_acc) begin
      if ((last_data >> 12) != last_src) mism++;
      if ((last_data & 12'hfff) != exp_seq[last_src]) mism++;
      exp_seq[last_src] = (last_data & 12'hfff) + 1;
      rcv++;
    end
    @(posedge clk);
    for (int i = 0; i < NQ; i++)
      if (p[i]) begin
        if (fq[i/NL][i%NL].size() == 0) proto++;
        else void'(fq[i/NL][i%NL].pop_front());
      end
    @(negedge clk);
    drive();
    #1;
  endtask

  function automatic int live_at(int start, logic [NL-1:0] m);
    for (int k = 0; k < NL; k++)
      if (!m[(start+k)%NL]) return (start+k)%NL;
    return start;
  endfunction

  task automatic send(int s, logic drop);
    int l;
    l = live_at(snd_ptr[s], snd_fail);
    if (!drop) fq[s][l].push_back((s << 12) | (snd_seq[s] & 12'hfff));
    snd_seq[s]++;
    snd_ptr[s] = live_at((l+1)%NL, snd_fail);
  endtask

  task automatic apply_reset();
    for (int s = 0; s < NS; s++) begin
      for (int l = 0; l < NL; l++) fq[s][l].delete();
      snd_ptr[s] = 0; snd_seq[s] = 0; exp_seq[s] = 0;
    end
    snd_fail = '0; mism = 0; rcv = 0; proto = 0; track = 0;
    out_ready = 0; frame_start = 0; resync_valid = 0; fail_mask = '0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    drive(); #1;
  endtask

  task automatic set_mask(logic [NL-1:0] m);
    fail_mask = m; frame_start = 1; snd_fail = m;
    tick();
    frame_start = 0;
  endtask

  task automatic t_reset_wait();
    apply_reset();
    chk(out_valid == 0 && q_pop == 0, "R1 idle after reset", out_valid, 0);
    fq[0][1].push_back(16'h0111);
    fq[0][2].push_back(16'h0222);
    out_ready = 1;
    drive(); #1;
    chk(out_valid == 0, "R2 waits on expected layer 0", out_valid, 0);
    tick();
    chk(fq[0][1].size() == 1 && fq[0][2].size() == 1, "R2 no out-of-turn pop",
        fq[0][1].size() + fq[0][2].size(), 2);
    out_ready = 0;
    fq[0][0].push_back(16'h0100);
    drive(); #1;
    chk(out_valid && out_layer == 0 && out_data == 16'h0100, "R1 pointer at layer 0",
        out_layer, 0);
    tick(); tick(); tick();
    chk(out_valid && out_layer == 0 && fq[0][0].size() == 1, "R4 stall holds pointer",
        out_layer, 0);
    chk(proto == 0, "R3 no pop without ready", proto, 0);
    out_ready = 1;
    tick();
    chk(last_acc && last_layer == 0 && last_data == 16'h0100, "R3 pop on accept",
        last_data, 16'h0100);
    chk(out_valid && out_layer == 1 && out_data == 16'h0111, "R4 advance to layer 1",
        out_layer, 1);
  endtask

  task automatic t_round_robin();
    int exp_s [6] = '{0, 1, 2, 0, 1, 2};
    int exp_l [6] = '{0, 0, 0, 1, 1, 1};
    int bad = 0;
    apply_reset();
    for (int s = 0; s < NS; s++) begin
      fq[s][0].push_back(s*16+0);
      fq[s][1].push_back(s*16+1);
    end
    out_ready = 1;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (!last_acc || last_src != exp_s[i] || last_layer != exp_l[i]) begin
        bad++;
        $display("FAIL R5 grant %0d: actual src=%0d layer=%0d expected src=%0d layer=%0d",
                 i, last_src, last_layer, exp_s[i], exp_l[i]);
      end
    end
    checks++;
    if (bad != 0) errors++;
    chk(out_valid == 0, "R5 all drained", out_valid, 0);
    chk(proto == 0, "R3 pop protocol in rotation", proto, 0);
  endtask

  task automatic t_fail_mask();
    apply_reset();
    for (int l = 0; l < NL; l++) fq[0][l].push_back(l);
    fail_mask = 4'b0010;
    out_ready = 1;
    tick();
    chk(out_valid && out_layer == 1, "R7 mask not applied without frame", out_layer, 1);
    out_ready = 0;
    set_mask(4'b0010);
    chk(out_valid && out_layer == 2, "R6 failed layer 1 skipped", out_layer, 2);
    out_ready = 1;
    tick();
    chk(out_valid && out_layer == 3, "R6 next live layer 3", out_layer, 3);
    tick();
    chk(out_valid == 0 && fq[0][1].size() == 1, "R6 failed queue never popped",
        fq[0][1].size(), 1);
    for (int l = 0; l < NL; l++) fq[1][l].push_back(l);
    out_ready = 0;
    set_mask(4'b1111);
    tick();
    chk(out_valid == 0, "R10 all layers failed", out_valid, 0);
    set_mask(4'b0000);
    chk(out_valid == 1, "R7 mask cleared at frame", out_valid, 1);
  endtask

  task automatic t_resync();
    apply_reset();
    for (int l = 0; l < NL; l++) begin
      fq[1][l].push_back(l);
      fq[1][l].push_back(l);
    end
    fq[1][1].push_back(1);
    out_ready = 1;
    tick(); tick();
    chk(out_valid && out_layer == 2, "R4 pointer at layer 2", out_layer, 2);
    out_ready = 0;
    resync_src = 1; resync_valid = 1;
    tick();
    resync_valid = 0;
    chk(out_valid && out_layer == 0, "R8 resync to layer 0", out_layer, 0);
    set_mask(4'b0001);
    chk(out_valid && out_layer == 1, "R8 first live layer", out_layer, 1);
    out_ready = 1; resync_valid = 1;
    tick();
    resync_valid = 0; out_ready = 0;
    chk(last_acc && last_layer == 1, "R8 accept during resync", last_layer, 1);
    chk(out_valid && out_layer == 1, "R8 resync beats advance", out_layer, 1);
  endtask

  task automatic run_traffic(int cycles, int pct);
    for (int c = 0; c < cycles; c++) begin
      if (($urandom % 100) < pct) send(int'($urandom % NS), 1'b0);
      out_ready = ($urandom % 4) != 0;
      tick();
    end
    out_ready = 1;
    for (int c = 0; c < 120; c++) tick();
  endtask

  task automatic t_flow();
    int sent;
    apply_reset();
    track = 1;
    run_traffic(500, 60);
    sent = snd_seq[0] + snd_seq[1] + snd_seq[2];
    chk(mism == 0 && rcv == sent, "R9 order with all layers", mism, 0);
    set_mask(4'b0100);
    run_traffic(500, 60);
    sent = snd_seq[0] + snd_seq[1] + snd_seq[2];
    chk(mism == 0 && rcv == sent, "R9 order with layer 2 failed", mism, 0);
    set_mask(4'b1001);
    run_traffic(500, 70);
    sent = snd_seq[0] + snd_seq[1] + snd_seq[2];
    chk(mism == 0 && rcv == sent, "R9 order with layers 0 and 3 failed", mism, 0);
    chk(proto == 0, "R3 pop protocol under traffic", proto, 0);
  endtask

  task automatic t_loss();
    apply_reset();
    track = 1;
    for (int i = 0; i < 8; i++) send(0, i == 1);
    out_ready = 1;
    for (int c = 0; c < 30; c++) tick();
    chk(mism > 0, "R9 loss produces misorder", mism, 1);
    for (int l = 0; l < NL; l++) fq[0][l].delete();
    snd_ptr[0] = 0;
    resync_src = 0; resync_valid = 1;
    tick();
    resync_valid = 0;
    exp_seq[0] = snd_seq[0];
    mism = 0; rcv = 0;
    for (int i = 0; i < 10; i++) send(0, 1'b0);
    for (int c = 0; c < 30; c++) tick();
    chk(mism == 0 && rcv == 10, "R9 resync restores order", mism, 0);
  endtask

  initial begin
    int wd_done = 0;
    fork
      begin
        t_reset_wait();
        t_round_robin();
        t_fail_mask();
        t_resync();
        t_flow();
        t_loss();
        wd_done = 1;
      end
      begin
        repeat (150000) @(posedge clk);
        wd_done = 2;
      end
    join_any
    if (wd_done != 1) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule